// File: doc/BRIEF.md
# Keepalive Status Packet Framer

This block takes the bytes that a scan shift engine reads back from a target and returns them to the host as short framed packets. Each byte offered on the write input goes into a 256-entry circular buffer. When the output side is free and bytes are waiting, the framer sends a packet. Each packet opens with two fixed status bytes, 0x31 followed by 0x60, and then carries up to 62 of the buffered bytes, oldest first. The output stream marks the first byte and the last byte of every packet.

Host software expects regular short transfers. A tick timer therefore forces a header-only packet whenever the buffer is empty and the timer period has elapsed. The timer flag is also set straight after every data packet, so a short packet closes each burst promptly. A flow-control output tells the command parser upstream whether it may take in more commands. It does so by keeping enough free space for the read-back of one full burst.

Top module: `ka_status_framer`

## Requirements
- R1: Every packet's first byte is 0x31, with out_first_o high. Its second byte is 0x60, with out_first_o low.
- R2: A packet carries at most MAX_PAY (62) payload bytes, so it is never longer than 64 bytes.
- R3: When a data packet starts, its payload length is min(pending, 62), where pending is the number of bytes stored and not yet sent. The payload bytes come out in the order they were written.
- R4: The buffer holds DEPTH (256) bytes and its read and write positions wrap around. Every byte that is accepted is eventually sent exactly once.
- R5: When nothing is pending and the keepalive flag is set, the framer sends a 2-byte header-only packet and clears the flag. Pending data always takes priority over a keepalive.
- R6: While the block is idle, header-only packets start exactly TICK_CYCLES clock cycles apart.
- R7: After the last byte of a data packet is transferred, the keepalive flag is set. With nothing pending, the first byte of a header-only packet is presented 2 cycles later.
- R8: accept_ok_o is high exactly when pending is below DEPTH-HEADROOM (193 by default).
- R9: out_last_o is high on the final byte of each packet and on no other byte.
- R10: A write that arrives while 256 bytes are pending is dropped. It sets overflow_o, which stays high until reset.
- R11: While out_busy_i is high, no packet starts, and a byte already presented stays on the output unchanged. A byte is transferred on a cycle with out_valid_o high and out_busy_i low.
- R12: After reset, out_valid_o is 0, accept_ok_o is 1 and overflow_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Read-back byte write strobe |
| wr_data_i | input | 8 | Read-back byte |
| out_busy_i | input | 1 | Output side cannot take a byte this cycle |
| out_valid_o | output | 1 | A packet byte is presented |
| out_data_o | output | 8 | Packet byte |
| out_first_o | output | 1 | Presented byte is the first of its packet |
| out_last_o | output | 1 | Presented byte is the last of its packet |
| accept_ok_o | output | 1 | Upstream may accept more command input |
| overflow_o | output | 1 | Sticky flag: a write was dropped because the buffer was full |

## Verification
The bench exercises the framer with several input patterns, and each one separates a different fault. A 100-byte backlog released at once must split into 62 and 38 payload bytes followed 2 cycles later by a header-only packet. This tells the min(pending, 62) split apart from the forced keepalive after data. Filling the buffer byte by byte across the 193 and 256 marks pins down the flow-control threshold and the dropped write. The bench checks that the dropped byte never appears in the drained output.

An idle stretch measures the keepalive spacing on its own. In the last pattern, the output is stalled on alternate cycles while sparse writes keep arriving after the indices have wrapped. This exposes lost, repeated or changing bytes under backpressure.

// File: rtl/ka_framer_pkg.sv
package ka_framer_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HDR0, ST_HDR1, ST_PAY} frm_state_e;
  localparam logic [7:0] HDR_B0 = 8'h31;
  localparam logic [7:0] HDR_B1 = 8'h60;
endpackage

// File: rtl/ka_ring_buf.sv
module ka_ring_buf #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic wr_ok, rd_ok;

  assign full_o    = (cnt_q == CW'(DEPTH));
  assign wr_ok     = wr_en_i && !full_o;
  assign rd_ok     = rd_en_i && (cnt_q != '0);
  assign rd_data_o = mem_q[rd_ptr_q];
  assign count_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_ptr_q] <= wr_data_i;
  end

  // Pointers wrap naturally at power-of-two depth
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_ok) rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/ka_tick_timer.sv
module ka_tick_timer #(
  parameter int TICK_CYCLES = 2500000,
  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_i,
  input  logic clear_i,
  output logic tick_o
);
  logic [TW-1:0] cnt_q;
  logic expire;

  assign expire = (cnt_q == TW'(TICK_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      cnt_q <= expire ? '0 : cnt_q + 1'b1;
      if (force_i)      tick_o <= 1'b1;
      else if (clear_i) tick_o <= 1'b0;
      else if (expire)  tick_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ka_pkt_seq.sv
module ka_pkt_seq
  import ka_framer_pkg::*;
#(
  parameter int MAX_PAY = 62,
  parameter int CW      = 9,
  localparam int LW     = $clog2(MAX_PAY + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic [CW-1:0] count_i,
  input  logic          tick_i,
  input  logic [7:0]    rd_data_i,
  output logic          pop_o,
  output logic          tick_clr_o,
  output logic          tick_set_o,
  output logic          out_valid_o,
  output logic [7:0]    out_data_o,
  output logic          out_first_o,
  output logic          out_last_o
);
  frm_state_e st_q;
  logic [LW-1:0] left_q, take;
  logic have_data;

  assign have_data  = (count_i != '0);
  assign take       = (count_i > CW'(MAX_PAY)) ? LW'(MAX_PAY) : LW'(count_i);
  assign tick_clr_o = (st_q == ST_IDLE) && !busy_i && !have_data && tick_i;
  assign pop_o      = (st_q == ST_PAY) && !busy_i;
  assign tick_set_o = pop_o && (left_q == LW'(1));

  assign out_valid_o = (st_q != ST_IDLE);
  assign out_first_o = (st_q == ST_HDR0);
  assign out_last_o  = ((st_q == ST_HDR1) && (left_q == '0)) ||
                       ((st_q == ST_PAY) && (left_q == LW'(1)));

  always_comb begin
    case (st_q)
      ST_HDR0: out_data_o = HDR_B0;
      ST_HDR1: out_data_o = HDR_B1;
      ST_PAY:  out_data_o = rd_data_i;
      default: out_data_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
    end else if (!busy_i) begin
      case (st_q)
        ST_IDLE: begin
          if (have_data) begin
            left_q <= take;
            st_q   <= ST_HDR0;
          end else if (tick_i) begin
            left_q <= '0;
            st_q   <= ST_HDR0;
          end
        end
        ST_HDR0: st_q <= ST_HDR1;
        ST_HDR1: st_q <= (left_q == '0) ? ST_IDLE : ST_PAY;
        ST_PAY: begin
          left_q <= left_q - 1'b1;
          if (left_q == LW'(1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ka_status_framer.sv
module ka_status_framer #(
  parameter int DEPTH       = 256,
  parameter int MAX_PAY     = 62,
  parameter int HEADROOM    = 63,
  parameter int TICK_CYCLES = 2500000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  input  logic       out_busy_i,
  output logic       out_valid_o,
  output logic [7:0] out_data_o,
  output logic       out_first_o,
  output logic       out_last_o,
  output logic       accept_ok_o,
  output logic       overflow_o
);
  localparam int AW           = $clog2(DEPTH);
  localparam int CW           = AW + 1;
  localparam int ACCEPT_LIMIT = DEPTH - HEADROOM;

  logic [CW-1:0] count;
  logic [7:0]    rd_data;
  logic full, pop, tick, tick_clr, tick_set;

  ka_ring_buf #(.DEPTH(DEPTH), .DW(8)) u_buf (
    .clk_i, .rst_ni,
    .wr_en_i(wr_valid_i), .wr_data_i(wr_data_i),
    .rd_en_i(pop), .rd_data_o(rd_data),
    .count_o(count), .full_o(full)
  );

  ka_tick_timer #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk_i, .rst_ni,
    .force_i(tick_set), .clear_i(tick_clr), .tick_o(tick)
  );

  ka_pkt_seq #(.MAX_PAY(MAX_PAY), .CW(CW)) u_seq (
    .clk_i, .rst_ni,
    .busy_i(out_busy_i), .count_i(count), .tick_i(tick), .rd_data_i(rd_data),
    .pop_o(pop), .tick_clr_o(tick_clr), .tick_set_o(tick_set),
    .out_valid_o, .out_data_o, .out_first_o, .out_last_o
  );

  assign accept_ok_o = (count < CW'(ACCEPT_LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 overflow_o <= 1'b0;
    else if (wr_valid_i && full) overflow_o <= 1'b1;
  end
endmodule

// File: rtl/ka_status_framer_chk.sv
module ka_status_framer_chk #(
  parameter int MAX_PKT = 64
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       out_busy_i,
  input logic       out_valid_o,
  input logic [7:0] out_data_o,
  input logic       out_first_o,
  input logic       out_last_o,
  input logic       overflow_o
);
  logic       xfer;
  logic [7:0] pkt_cnt_q;

  assign xfer = out_valid_o && !out_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pkt_cnt_q <= '0;
    else if (xfer) pkt_cnt_q <= out_last_o ? '0 : pkt_cnt_q + 1'b1;
  end

  assert_hdr_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_first_o |-> out_data_o == 8'h31);
  assert_hdr_second_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer && out_first_o |=> out_valid_o && !out_first_o && out_data_o == 8'h60);
  assert_pkt_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer && out_last_o |-> pkt_cnt_q < 8'(MAX_PKT));
  assert_last_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer && out_last_o |=> !out_valid_o || out_first_o);
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_busy_i |=> out_valid_o && $stable(out_data_o) && $stable(out_first_o));
  assert_no_start_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o && out_busy_i |=> !out_valid_o);
  assert_ovf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
endmodule

bind ka_status_framer ka_status_framer_chk #(.MAX_PKT(MAX_PAY + 2)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .out_busy_i(out_busy_i),
  .out_valid_o(out_valid_o), .out_data_o(out_data_o),
  .out_first_o(out_first_o), .out_last_o(out_last_o),
  .overflow_o(overflow_o)
);

// File: tb/ka_status_framer_tb.sv
module ka_status_framer_tb;
  localparam int TICK = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, busy = 1'b0;
  logic [7:0] wr_data = '0;
  logic out_valid, out_first, out_last, accept_ok, overflow;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  ka_status_framer #(.TICK_CYCLES(TICK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .out_busy_i(busy), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_first_o(out_first), .out_last_o(out_last),
    .accept_ok_o(accept_ok), .overflow_o(overflow)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, bcount = 0, seed = 0;
  logic [7:0] exp_q[$];
  int lens[$], starts[$], ends[$];
  int pos = 0, pkt_start = 0;
  bit prev_hold = 0;
  logic [7:0] prev_d = '0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops expected payload, checks framing
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_hold && out_valid) chk(out_data == prev_d, "R11 held byte", out_data, prev_d);
      prev_hold = out_valid && busy;
      prev_d    = out_data;
      if (out_valid && !busy) begin
        if (pos == 0) begin
          chk(out_first == 1'b1, "R1 first marker", out_first, 1);
          chk(out_data == 8'h31, "R1 header byte 0", out_data, 8'h31);
          pkt_start = cyc;
        end else if (pos == 1) begin
          chk(out_data == 8'h60 && !out_first, "R1 header byte 1", out_data, 8'h60);
        end else if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected payload", out_data, -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R3 payload order", out_data, e);
        end
        chk(pos < 64, "R2 packet length", pos + 1, 64);
        if (out_last) begin
          lens.push_back(pos + 1);
          starts.push_back(pkt_start);
          ends.push_back(cyc);
          pos = 0;
        end else pos++;
      end
    end
  end

  task automatic push_bytes(input int n, input int gap, input bit track);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'(seed * 7 + 3);
      seed++;
      @(posedge clk); #1;
      wr_valid = 1'b1;
      wr_data  = d;
      if (!track || bcount < 256) exp_q.push_back(d);
      if (track && bcount < 256) bcount++;
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #1;
        wr_valid = 1'b0;
      end
    end
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_log();
    lens.delete(); starts.delete(); ends.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 reset valid", out_valid, 0);
    chk(accept_ok == 1'b1, "R12 reset accept", accept_ok, 1);
    chk(overflow == 1'b0, "R12 reset overflow", overflow, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    busy  = 1'b1;

    // Backlog of 100 bytes released at once
    bcount = 0;
    push_bytes(100, 0, 1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 no start while busy", out_valid, 0);
    chk(accept_ok == 1'b1, "R8 accept at 100", accept_ok, 1);
    clear_log();
    @(posedge clk); #1;
    busy = 1'b0;
    wait_cyc(150);
    chk(lens.size() >= 3, "R7 packet count", lens.size(), 3);
    if (lens.size() >= 3) begin
      chk(lens[0] == 64, "R3 first split", lens[0], 64);
      chk(lens[1] == 40, "R3 second split", lens[1], 40);
      chk(lens[2] == 2, "R7 header-only follows", lens[2], 2);
      chk(starts[2] - ends[1] == 2, "R7 gap", starts[2] - ends[1], 2);
    end
    chk(exp_q.size() == 0, "R3 drained", exp_q.size(), 0);

    // Flow-control threshold and overflow
    @(posedge clk); #1;
    busy = 1'b1;
    bcount = 0;
    push_bytes(192, 0, 1);
    @(negedge clk);
    chk(accept_ok == 1'b1, "R8 accept at 192", accept_ok, 1);
    push_bytes(1, 0, 1);
    @(negedge clk);
    chk(accept_ok == 1'b0, "R8 accept at 193", accept_ok, 0);
    push_bytes(63, 0, 1);
    @(negedge clk);
    chk(overflow == 1'b0, "R10 full no overflow", overflow, 0);
    push_bytes(1, 0, 1);
    @(negedge clk);
    chk(overflow == 1'b1, "R10 overflow set", overflow, 1);
    clear_log();
    @(posedge clk); #1;
    busy = 1'b0;
    wait_cyc(400);
    chk(lens.size() >= 5, "R9 packet count", lens.size(), 5);
    if (lens.size() >= 5) begin
      for (int k = 0; k < 4; k++) chk(lens[k] == 64, "R2 full packet", lens[k], 64);
      chk(lens[4] == 10, "R9 tail packet", lens[4], 10);
    end
    chk(exp_q.size() == 0, "R4 dropped byte absent", exp_q.size(), 0);
    chk(overflow == 1'b1, "R10 sticky", overflow, 1);
    chk(accept_ok == 1'b1, "R8 accept after drain", accept_ok, 1);

    // Idle keepalive spacing
    wait_cyc(200);
    clear_log();
    wait_cyc(1000);
    chk(starts.size() >= 3, "R5 keepalive count", starts.size(), 3);
    foreach (lens[k]) chk(lens[k] == 2, "R5 header only", lens[k], 2);
    if (starts.size() >= 3) begin
      chk(starts[1] - starts[0] == TICK, "R6 interval a", starts[1] - starts[0], TICK);
      chk(starts[2] - starts[1] == TICK, "R6 interval b", starts[2] - starts[1], TICK);
    end

    // Alternating stall with sparse writes after wrap
    fork
      begin
        repeat (320) begin
          @(posedge clk); #1;
          busy = ~busy;
        end
      end
      push_bytes(150, 1, 0);
    join
    @(posedge clk); #1;
    busy = 1'b0;
    wait_cyc(300);
    chk(exp_q.size() == 0, "R4 stream complete", exp_q.size(), 0);
    chk(pos == 0, "R9 ended on packet boundary", pos, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule